// File: doc/BRIEF.md
# Beacon-Synchronized Time-Slot Bus Arbiter

This block decides when a node on a shared half-duplex multidrop bus may transmit. Every node carries a local ID, and the nodes take turns in slot order. A slot is short when its owner has nothing to send. It grows to the length of a packet when a node commits to it, or when a packet from another node is received during it. The node with ID zero is the master. It sends a beacon that restarts the slot count on every node, so that all nodes agree on whose turn it is.

The block runs on a clock of one bit time. It watches a carrier indication, a receiving flag and a beacon-detected flag from the receive path, together with a frame-pending request from the local MAC side. It drives a 5-bit line command, which is silence, SYNC or BEACON, and a committed flag. The committed flag tells the surrounding logic that the current slot belongs to this node. The local transmit enable marks the end of the node's own transmission. A lost or false carrier is handled in one of two ways. A slave falls back to waiting for a beacon. The master waits for a long quiet period on the bus and then beacons again.

Top module: `slot_arbiter`

## Requirements
- R1: While en_i is low, and in reset, tx_cmd_o is 5'b11111 (silence) and committed_o is 0. Lowering en_i in any state gives silence and committed_o = 0 from the next cycle on.
- R2: A node with my_id_i = 0 is the master. On enable it drives tx_cmd_o = 5'b01000 (BEACON) from the next cycle, for exactly BEACON_BITS cycles. Slaves never drive BEACON.
- R3: The slot count restarts at 0 when a beacon ends. For the master this happens when its own beacon ends. For a slave it happens on the cycle after beacon_i falls while the slave waits for synchronisation. Slot 0 starts on the next cycle.
- R4: A slot with no carrier lasts TS_BITS cycles, after which the slot count advances. A node with ID k that has a frame pending therefore commits k*TS_BITS+1 cycles after slot 0 starts.
- R5: frame_pending_i is sampled only in the first cycle of the node's own slot. If it is high, the node commits on the next cycle: committed_o = 1 and tx_cmd_o = 5'b11000 (SYNC). A request that arrives later in the slot is ignored.
- R6: While committed, SYNC is driven until tx_en_i rises, and silence while tx_en_i is high. When tx_en_i falls, committed_o drops on the next cycle and the next slot starts.
- R7: A carrier in a slot stops the slot timer. If receiving_i then rises, the node holds the slot, with no timeout, until receiving_i falls. The next slot then starts with a freshly armed timer.
- R8: A beacon_i seen while a carrier is pending sends the node to resynchronisation. Slot 0 restarts when that beacon ends.
- R9: If the carrier is not followed by receiving_i within RECV_BITS cycles, a slave waits for a new beacon. Until that beacon ends, it ignores receiving_i and never commits.
- R10: On the same receive timeout, the master waits until carrier_i has been low for TS_BITS*(max_id_i+1) consecutive cycles, then beacons. Any carrier restarts that count.
- R11: The master beacons again as soon as the slot count passes max_id_i, whether the last slot was yielded, received or used by the master itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-time clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Arbitration enable |
| my_id_i | input | ID_W | Local node ID; 0 selects master |
| max_id_i | input | ID_W | Highest node ID in a cycle (master only) |
| carrier_i | input | 1 | Receive path has locked onto line activity |
| receiving_i | input | 1 | Receive path is decoding a packet |
| beacon_i | input | 1 | Receive path is seeing a beacon |
| frame_pending_i | input | 1 | Local MAC has a frame waiting |
| tx_en_i | input | 1 | Local transmission in progress |
| committed_o | output | 1 | Current slot is owned by this node |
| tx_cmd_o | output | 5 | Line command: 11111 silence, 11000 SYNC, 01000 BEACON |

## Verification
The slot timing is measured through the commit instant alone. Slaves with IDs 1 to 6 each hold a pending frame, and the cycle of commit after the beacon separates a correct slot length and advance order from off-by-one slot or start errors. Masters with max_id_i from 0 to 3 are checked on beacon length and beacon period, which shows where the cycle wraps. Interrupted slots are covered by four patterns: a carrier followed by a long reception, a carrier followed by a beacon, a carrier that times out on a slave, and a carrier that times out on a master, with and without a second carrier during the quiet wait. Each pattern lands the commit or the beacon on a different cycle when the halt, re-arm or recovery rule is broken. A request raised one cycle into the node's own slot, and a drop of the enable in mid-beacon or mid-commit, cover the rules on what is ignored.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RESYNC, ST_BEACON, ST_WAIT, ST_CARRIER,
    ST_RECEIVE, ST_COMMIT, ST_XMIT, ST_RECOVER
  } arb_state_e;

  localparam logic [4:0] SYM_SILENCE = 5'b11111;
  localparam logic [4:0] SYM_SYNC    = 5'b11000;
  localparam logic [4:0] SYM_BEACON  = 5'b01000;
endpackage

// File: rtl/arb_timer.sv
module arb_timer #(
  parameter int LIMIT = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LIMIT));
endmodule

// File: rtl/arb_silence_watch.sv
// Counts consecutive quiet cycles up to TS_BITS*(max_id+1) without a multiplier.
module arb_silence_watch #(
  parameter int ID_W    = 8,
  parameter int TS_BITS = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            run_i,
  input  logic [ID_W-1:0] max_id_i,
  output logic            done_o
);
  localparam int BW = $clog2(TS_BITS + 1);
  logic [BW-1:0]   bit_q;
  logic [ID_W-1:0] slot_q;
  logic            bit_wrap;

  assign bit_wrap = (bit_q == BW'(TS_BITS - 1));
  assign done_o   = run_i && bit_wrap && (slot_q == max_id_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      slot_q <= '0;
    end else if (clr_i || done_o) begin
      bit_q  <= '0;
      slot_q <= '0;
    end else if (run_i) begin
      bit_q <= bit_wrap ? '0 : bit_q + 1'b1;
      if (bit_wrap) slot_q <= slot_q + 1'b1;
    end
  end

  p_slot_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i) |-> (slot_q <= max_id_i));
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import arb_pkg::*;
#(
  parameter int ID_W        = 8,
  parameter int TS_BITS     = 20,
  parameter int BEACON_BITS = 20,
  parameter int RECV_BITS   = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [ID_W-1:0] my_id_i,
  input  logic [ID_W-1:0] max_id_i,
  input  logic            carrier_i,
  input  logic            receiving_i,
  input  logic            beacon_i,
  input  logic            frame_pending_i,
  input  logic            tx_en_i,
  output logic            committed_o,
  output logic [4:0]      tx_cmd_o
);
  arb_state_e      state_q, state_d;
  logic [ID_W-1:0] cur_id_q, cur_id_d, nxt_id;
  logic            bcn_q, first_q, first_d;
  logic            ts_done, bcn_done, recv_done, sil_done;
  logic            is_master, own_slot, last_slot, bcn_end;

  assign is_master = (my_id_i == '0);
  assign own_slot  = (cur_id_q == my_id_i);
  assign last_slot = is_master && (cur_id_q >= max_id_i);
  assign bcn_end   = bcn_q && !beacon_i;
  assign nxt_id    = cur_id_q + 1'b1;

  arb_timer #(.LIMIT(TS_BITS)) u_ts (
    .clk_i, .rst_ni,
    .clr_i (state_q != ST_WAIT),
    .run_i (state_q == ST_WAIT),
    .done_o(ts_done)
  );

  arb_timer #(.LIMIT(BEACON_BITS)) u_bcn (
    .clk_i, .rst_ni,
    .clr_i (state_q != ST_BEACON),
    .run_i (state_q == ST_BEACON),
    .done_o(bcn_done)
  );

  arb_timer #(.LIMIT(RECV_BITS)) u_recv (
    .clk_i, .rst_ni,
    .clr_i (state_q != ST_CARRIER),
    .run_i (state_q == ST_CARRIER),
    .done_o(recv_done)
  );

  arb_silence_watch #(.ID_W(ID_W), .TS_BITS(TS_BITS)) u_sil (
    .clk_i, .rst_ni,
    .clr_i   ((state_q != ST_RECOVER) || carrier_i),
    .run_i   (state_q == ST_RECOVER),
    .max_id_i(max_id_i),
    .done_o  (sil_done)
  );

  always_comb begin
    state_d  = state_q;
    cur_id_d = cur_id_q;
    if (!en_i) begin
      state_d  = ST_IDLE;
      cur_id_d = '0;
    end else begin
      unique case (state_q)
        ST_IDLE:   state_d = is_master ? ST_BEACON : ST_RESYNC;
        ST_RESYNC: if (bcn_end) begin
          state_d  = ST_WAIT;
          cur_id_d = '0;
        end
        ST_BEACON: if (bcn_done) begin
          state_d  = ST_WAIT;
          cur_id_d = '0;
        end
        ST_WAIT: begin
          if (carrier_i)                                     state_d = ST_CARRIER;
          else if (own_slot && first_q && frame_pending_i)   state_d = ST_COMMIT;
          else if (ts_done) begin
            if (last_slot) state_d = ST_BEACON;
            else           cur_id_d = nxt_id;
          end
        end
        ST_CARRIER: begin
          if (beacon_i)         state_d = ST_RESYNC;
          else if (receiving_i) state_d = ST_RECEIVE;
          else if (recv_done)   state_d = is_master ? ST_RECOVER : ST_RESYNC;
        end
        ST_RECEIVE, ST_XMIT: begin
          if ((state_q == ST_RECEIVE) ? !receiving_i : !tx_en_i) begin
            if (last_slot) state_d = ST_BEACON;
            else begin
              state_d  = ST_WAIT;
              cur_id_d = nxt_id;
            end
          end
        end
        ST_COMMIT:  if (tx_en_i) state_d = ST_XMIT;
        ST_RECOVER: if (sil_done) state_d = ST_BEACON;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  // high in the first cycle of every slot
  assign first_d = (state_d == ST_WAIT) &&
                   ((state_q != ST_WAIT) || (cur_id_d != cur_id_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cur_id_q <= '0;
      bcn_q    <= 1'b0;
      first_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      cur_id_q <= cur_id_d;
      bcn_q    <= en_i && beacon_i;
      first_q  <= first_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_BEACON: tx_cmd_o = SYM_BEACON;
      ST_COMMIT: tx_cmd_o = SYM_SYNC;
      default:   tx_cmd_o = SYM_SILENCE;
    endcase
  end
  assign committed_o = (state_q == ST_COMMIT) || (state_q == ST_XMIT);

  p_off_silent_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (tx_cmd_o == SYM_SILENCE && !committed_o));

  p_beacon_master_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cmd_o == SYM_BEACON) |-> (my_id_i == '0));

  p_commit_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(committed_o) |-> $past(own_slot && first_q && frame_pending_i));

  p_sync_owned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cmd_o == SYM_SYNC) |-> committed_o);

  p_xmit_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (committed_o && en_i && tx_cmd_o == SYM_SILENCE && !tx_en_i) |=> !committed_o);
endmodule

// File: tb/sim_slot_arbiter.sv
module sim_slot_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int TS  = 5;
  localparam int BCN = 6;
  localparam int RCV = 12;
  localparam int WD  = 20000;
  localparam logic [4:0] SIL = 5'b11111, SYN = 5'b11000, BEA = 5'b01000;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic carrier = 1'b0, receiving = 1'b0, beacon = 1'b0, pending = 1'b0, tx_en = 1'b0;
  logic [7:0] my_id = '0, max_id = '0;
  logic committed;
  logic [4:0] tx_cmd;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_arbiter #(.ID_W(8), .TS_BITS(TS), .BEACON_BITS(BCN), .RECV_BITS(RCV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .my_id_i(my_id), .max_id_i(max_id),
    .carrier_i(carrier), .receiving_i(receiving), .beacon_i(beacon),
    .frame_pending_i(pending), .tx_en_i(tx_en),
    .committed_o(committed), .tx_cmd_o(tx_cmd)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic go_off();
    en = 0; carrier = 0; receiving = 0; beacon = 0; pending = 0; tx_en = 0;
    step(); step();
  endtask

  // leaves the bench just after the edge that starts slot 0
  task automatic slave_sync(input int id);
    my_id = 8'(id); en = 1;
    step();
    beacon = 1; step();
    beacon = 0; step();
  endtask

  task automatic wait_commit(input int lim, output int n);
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      step();
      if (committed) begin n = i; break; end
    end
  endtask

  task automatic wait_beacon(input int lim, output int n);
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      step();
      if (tx_cmd == BEA) begin n = i; break; end
    end
  endtask

  initial begin
    for (int i = 0; i < WD; i++) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WD, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int n, m, bl, bad;
    #3;
    chk_eq("R1 reset cmd", tx_cmd, SIL);
    chk_eq("R1 reset committed", committed, 0);
    step(); rst_n = 1;
    repeat (3) step();
    chk_eq("R1 disabled cmd", tx_cmd, SIL);

    // slave slot positions, commit and release
    for (int k = 1; k <= 6; k++) begin
      go_off(); pending = 1;
      slave_sync(k);
      wait_commit(200, n);
      chk_eq($sformatf("R4 R3 slave %0d commit cycle", k), n, k*TS + 1);
      chk_eq("R5 sync on commit", tx_cmd, SYN);
      tx_en = 1; step();
      chk_eq("R6 silence while sending", tx_cmd, SIL);
      chk_eq("R6 committed held", committed, 1);
      tx_en = 0; step();
      chk_eq("R6 committed released", committed, 0);
    end

    // master beacon length and period
    for (int mx = 0; mx <= 3; mx++) begin
      go_off(); my_id = 0; max_id = 8'(mx); en = 1;
      step(); n = 1;
      chk_eq("R2 beacon after enable", tx_cmd, BEA);
      bl = 1;
      for (int i = 0; i < 100; i++) begin
        step(); n++;
        if (tx_cmd == BEA) bl++; else break;
      end
      chk_eq("R2 beacon length", bl, BCN);
      wait_beacon(200, m);
      chk_eq($sformatf("R11 beacon period max_id=%0d", mx), n + m, BCN + 1 + (mx+1)*TS);
    end

    // master owns slot 0, wraps after its own transmission
    go_off(); my_id = 0; max_id = 0; pending = 1; en = 1;
    wait_commit(200, n);
    chk_eq("R3 master slot 0 commit", n, BCN + 2);
    tx_en = 1; step();
    pending = 0; tx_en = 0; step();
    chk_eq("R11 beacon after own slot", tx_cmd, BEA);

    // late request ignored
    go_off(); pending = 0;
    slave_sync(2);
    repeat (2*TS + 1) step();
    pending = 1; bad = 0;
    repeat (3*TS) begin step(); if (committed) bad++; end
    chk_eq("R5 late request ignored", bad, 0);

    // carrier then long reception
    go_off(); pending = 1;
    slave_sync(3);
    step(); carrier = 1; step();
    receiving = 1; step(); bad = 0;
    repeat (RCV + 3) begin step(); if (committed) bad++; end
    chk_eq("R7 no commit while receiving", bad, 0);
    receiving = 0; carrier = 0;
    wait_commit(200, n);
    chk_eq("R7 slot after reception", n, 2*TS + 2);

    // beacon while carrier pending
    go_off(); pending = 1;
    slave_sync(2);
    step(); carrier = 1; step();
    beacon = 1; step();
    beacon = 0; carrier = 0;
    wait_commit(200, n);
    chk_eq("R8 resync on beacon", n, 2*TS + 2);

    // slave receive timeout
    go_off(); pending = 1;
    slave_sync(1);
    carrier = 1; step(); carrier = 0; bad = 0;
    repeat (RCV + 3) begin step(); if (committed) bad++; end
    receiving = 1; step(); step(); receiving = 0;
    repeat (3*TS) begin step(); if (committed) bad++; end
    chk_eq("R9 slave silent after timeout", bad, 0);
    beacon = 1; step(); beacon = 0; step();
    wait_commit(200, n);
    chk_eq("R9 slave back after beacon", n, TS + 1);

    // master recovery
    go_off(); my_id = 0; max_id = 1; en = 1;
    repeat (BCN + 1) step();
    carrier = 1; step(); carrier = 0;
    wait_beacon(300, m);
    chk_eq("R10 master quiet then beacon", m, RCV + 2*TS);
    go_off(); en = 1;
    repeat (BCN + 1) step();
    carrier = 1; step(); carrier = 0;
    repeat (RCV + 3) step();
    carrier = 1; step(); carrier = 0;
    wait_beacon(300, m);
    chk_eq("R10 carrier restarts quiet count", m, 2*TS);

    // disable mid-beacon and mid-commit
    go_off(); my_id = 0; en = 1;
    step(); step(); en = 0; step();
    chk_eq("R1 stop mid-beacon", tx_cmd, SIL);
    go_off(); pending = 1;
    slave_sync(1);
    wait_commit(200, n);
    en = 0; step();
    chk_eq("R1 stop mid-commit", committed, 0);
    chk_eq("R1 stop mid-commit cmd", tx_cmd, SIL);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule